// File: doc/BRIEF.md
# Blacklisting Memory Request Scheduler

This block picks the next request to issue from a shared memory request queue whose entries come from several applications. Each queue slot presents a valid bit, an application number, a row-hit flag and an age. The scheduler sorts applications into just two classes, clean and blacklisted, and does not keep a full ranking. An application moves into the blacklisted class when it has been served too many times in a row. A single streak counter tracks those back-to-back services. A free-running interval timer periodically empties the blacklist, so that no application stays penalised for ever.

The grant side is a valid/ready stream. `grant_valid` and `grant_idx` are combinational in the current queue contents. A transfer takes place in any cycle where `grant_valid` and `grant_ready` are both high. The consumer may hold `grant_ready` low for as long as it likes. While it does, the scheduler's state does not move, and the grant keeps following the queue inputs. A grant that is not accepted leaves no trace. The queue owner removes the served entry on its own side after a transfer.

Top module: `mem_blacklist_sched`

## Requirements
- R1: `grant_valid` is high exactly when at least one `req_valid` bit is set. Whenever it is high, `grant_idx` names a slot whose `req_valid` bit is set.
- R2: A valid request from an application whose blacklist bit is clear is always granted ahead of any request from a blacklisted application.
- R3: Among requests of the same class, a request with `req_rowhit` = 1 is granted ahead of one with `req_rowhit` = 0, whatever their ages.
- R4: Among requests equal in class and row-hit, the one with the larger `req_age` is granted, since a larger value means older. If the ages are also equal, the lowest slot index wins.
- R5: A service happens only in a cycle with `grant_valid` = 1 and `grant_ready` = 1. In any other cycle the streak counter, the last-served record and the blacklist bits do not change. The one exception is the periodic clear of R8.
- R6: When a service goes to the same application as the previous service, the streak counter increments, saturating at `BL_THRESH`. When it goes to a different application, or is the first service after reset, the counter is set to 1 and that application is recorded as last served.
- R7: When a service brings the streak counter to `BL_THRESH` (default 4), the served application's blacklist bit is set. The bit then stays set until the next clear.
- R8: Every `CLEAR_INTERVAL` cycles (default 10000, counted from reset release), all blacklist bits are cleared in the same cycle. A clear takes precedence over a set in that cycle. The clear does not alter the streak counter.
- R9: After reset the blacklist is empty, the streak counter is 0 and no application is recorded as last served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | QDEPTH | Per-slot request present |
| req_app | input | QDEPTH*APP_W | Per-slot application number, slot i at bits [i*APP_W +: APP_W] |
| req_rowhit | input | QDEPTH | Per-slot row-hit flag |
| req_age | input | QDEPTH*AGE_W | Per-slot age, larger is older, slot i at bits [i*AGE_W +: AGE_W] |
| grant_ready | input | 1 | Consumer accepts the offered grant |
| grant_valid | output | 1 | A grant is offered |
| grant_idx | output | IDX_W | Slot index of the offered grant |

## Verification
The arbiter is tried with queues that differ in only one attribute at a time. Age-only patterns show oldest-first ordering and the low-index tie-break. Young row hits against old misses show that row-hit outranks age. Streams of back-to-back services for one application set its blacklist bit, and that application then loses to a younger clean request. An interrupted streak, where a single service to another application breaks the run, shows that the counter restarts instead of accumulating. Long stretches with `grant_ready` held low tell a design that counts offers apart from one that counts services, and a wait past the clearing interval shows a blacklisted application winning again on age.

// File: rtl/blsched_pkg.sv
`timescale 1ns/1ps
package blsched_pkg;
  // Width helper: at least one bit for any count.
  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/blsched_interval_timer.sv
`timescale 1ns/1ps
// Free-running timer producing a one-cycle clear pulse every PERIOD cycles.
module blsched_interval_timer #(
  parameter int PERIOD = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  import blsched_pkg::*;
  localparam int TW = safe_clog2(PERIOD);
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] count_q;

  assign tick = (count_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + 1'b1;
    end
  end
endmodule

// File: rtl/blsched_streak_tracker.sv
`timescale 1ns/1ps
// Tracks back-to-back services of one application and owns the blacklist bits.
module blsched_streak_tracker #(
  parameter int NUM_APPS  = 4,
  parameter int BL_THRESH = 4,
  parameter int APP_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                served,
  input  logic [APP_W-1:0]    served_app,
  input  logic                clear,
  output logic [NUM_APPS-1:0] blacklist,
  output logic [CNT_W-1:0]    streak,
  output logic [APP_W-1:0]    last_app,
  output logic                last_vld
);
  localparam logic [CNT_W-1:0] THR = CNT_W'(BL_THRESH);

  logic [CNT_W-1:0]    streak_q, streak_d;
  logic [APP_W-1:0]    last_q;
  logic                lvld_q;
  logic [NUM_APPS-1:0] bl_q, set_vec;
  logic                same_app;

  assign same_app = lvld_q && (last_q == served_app);

  always_comb begin
    streak_d = streak_q;
    if (served) begin
      if (same_app) begin
        streak_d = (streak_q >= THR) ? streak_q : streak_q + 1'b1;
      end else begin
        streak_d = CNT_W'(1);
      end
    end
  end

  // One-hot set request for the served application when the streak reaches the limit.
  genvar a;
  generate
    for (a = 0; a < NUM_APPS; a++) begin : g_set
      assign set_vec[a] = served && (streak_d >= THR) && (served_app == APP_W'(a));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak_q <= '0;
      last_q   <= '0;
      lvld_q   <= 1'b0;
      bl_q     <= '0;
    end else begin
      streak_q <= streak_d;
      if (served) begin
        last_q <= served_app;
        lvld_q <= 1'b1;
      end
      bl_q <= clear ? '0 : (bl_q | set_vec);
    end
  end

  assign blacklist = bl_q;
  assign streak    = streak_q;
  assign last_app  = last_q;
  assign last_vld  = lvld_q;
endmodule

// File: rtl/blsched_pick_tree.sv
`timescale 1ns/1ps
// Binary maximum tree over per-slot priority keys; ties go to the lower slot index.
module blsched_pick_tree #(
  parameter int QDEPTH = 8,
  parameter int KEY_W  = 11,
  parameter int IDX_W  = 3
) (
  input  logic [QDEPTH*KEY_W-1:0] keys,
  output logic [KEY_W-1:0]        win_key,
  output logic [IDX_W-1:0]        win_idx
);
  localparam int LEAVES = 1 << $clog2(QDEPTH);
  localparam int NODES  = 2 * LEAVES - 1;

  logic [KEY_W-1:0] node_key [NODES];
  logic [IDX_W-1:0] node_idx [NODES];

  genvar i, n;
  generate
    for (i = 0; i < LEAVES; i++) begin : g_leaf
      if (i < QDEPTH) begin : g_real
        assign node_key[LEAVES-1+i] = keys[i*KEY_W +: KEY_W];
      end else begin : g_pad
        assign node_key[LEAVES-1+i] = '0;
      end
      assign node_idx[LEAVES-1+i] = IDX_W'(i);
    end
    for (n = 0; n < LEAVES - 1; n++) begin : g_node
      logic take_right;
      assign take_right  = node_key[2*n+2] > node_key[2*n+1];
      assign node_key[n] = take_right ? node_key[2*n+2] : node_key[2*n+1];
      assign node_idx[n] = take_right ? node_idx[2*n+2] : node_idx[2*n+1];
    end
  endgenerate

  assign win_key = node_key[0];
  assign win_idx = node_idx[0];
endmodule

// File: rtl/mem_blacklist_sched.sv
`timescale 1ns/1ps
// Two-class memory request scheduler with streak-based blacklisting.
module mem_blacklist_sched #(
  parameter int NUM_APPS       = 4,
  parameter int QDEPTH         = 8,
  parameter int AGE_W          = 8,
  parameter int BL_THRESH      = 4,
  parameter int CLEAR_INTERVAL = 10000,
  localparam int APP_W = blsched_pkg::safe_clog2(NUM_APPS),
  localparam int IDX_W = blsched_pkg::safe_clog2(QDEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [QDEPTH-1:0]       req_valid,
  input  logic [QDEPTH*APP_W-1:0] req_app,
  input  logic [QDEPTH-1:0]       req_rowhit,
  input  logic [QDEPTH*AGE_W-1:0] req_age,
  input  logic                    grant_ready,
  output logic                    grant_valid,
  output logic [IDX_W-1:0]        grant_idx
);
  import blsched_pkg::*;
  // Key layout, most significant first: valid, clean class, row hit, age.
  localparam int KEY_W = AGE_W + 3;
  localparam int CNT_W = safe_clog2(BL_THRESH + 1);

  logic [NUM_APPS-1:0]     bl_vec;
  logic [CNT_W-1:0]        streak_cnt;
  logic [APP_W-1:0]        last_app;
  logic                    last_vld;
  logic                    clear_pulse;
  logic [QDEPTH*KEY_W-1:0] slot_keys;
  logic [KEY_W-1:0]        top_key;
  logic                    served;
  logic [APP_W-1:0]        served_app;

  genvar s;
  generate
    for (s = 0; s < QDEPTH; s++) begin : g_key
      logic [APP_W-1:0] app_s;
      logic             bl_s;
      assign app_s = req_app[s*APP_W +: APP_W];
      assign bl_s  = (int'(app_s) < NUM_APPS) ? bl_vec[app_s] : 1'b0;
      assign slot_keys[s*KEY_W +: KEY_W] =
        {req_valid[s], ~bl_s, req_rowhit[s], req_age[s*AGE_W +: AGE_W]};
    end
  endgenerate

  blsched_pick_tree #(
    .QDEPTH(QDEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)
  ) u_pick (
    .keys   (slot_keys),
    .win_key(top_key),
    .win_idx(grant_idx)
  );

  assign grant_valid = top_key[KEY_W-1];
  assign served      = grant_valid && grant_ready;
  assign served_app  = req_app[grant_idx*APP_W +: APP_W];

  blsched_interval_timer #(.PERIOD(CLEAR_INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (clear_pulse)
  );

  blsched_streak_tracker #(
    .NUM_APPS(NUM_APPS), .BL_THRESH(BL_THRESH), .APP_W(APP_W), .CNT_W(CNT_W)
  ) u_streak (
    .clk       (clk),
    .rst_n     (rst_n),
    .served    (served),
    .served_app(served_app),
    .clear     (clear_pulse),
    .blacklist (bl_vec),
    .streak    (streak_cnt),
    .last_app  (last_app),
    .last_vld  (last_vld)
  );
endmodule

// File: rtl/mem_blacklist_sched_chk.sv
`timescale 1ns/1ps
module mem_blacklist_sched_chk #(
  parameter int NUM_APPS = 4,
  parameter int QDEPTH   = 8,
  parameter int APP_W    = 2,
  parameter int IDX_W    = 3,
  parameter int CNT_W    = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [QDEPTH-1:0]       req_valid,
  input logic [QDEPTH*APP_W-1:0] req_app,
  input logic                    grant_valid,
  input logic                    grant_ready,
  input logic [IDX_W-1:0]        grant_idx,
  input logic [NUM_APPS-1:0]     bl_vec,
  input logic [CNT_W-1:0]        streak_cnt,
  input logic [APP_W-1:0]        last_app,
  input logic                    last_vld,
  input logic                    clear_pulse
);
  logic [QDEPTH-1:0] clean_pending;
  logic [APP_W-1:0]  g_app;
  logic              g_bl, xfer;

  genvar i;
  generate
    for (i = 0; i < QDEPTH; i++) begin : g_cp
      logic [APP_W-1:0] ap;
      assign ap = req_app[i*APP_W +: APP_W];
      assign clean_pending[i] = req_valid[i] && !((int'(ap) < NUM_APPS) && bl_vec[ap]);
    end
  endgenerate

  assign g_app = req_app[grant_idx*APP_W +: APP_W];
  assign g_bl  = (int'(g_app) < NUM_APPS) && bl_vec[g_app];
  assign xfer  = grant_valid && grant_ready;

  // R1
  grant_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (|req_valid));
  // R1
  grant_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req_valid[grant_idx]);
  // R2
  class_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && g_bl) |-> (clean_pending == '0));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !clear_pulse) |=> ($stable(bl_vec) && $stable(streak_cnt)));
  // R6
  streak_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && (!last_vld || last_app != g_app)) |=> (streak_cnt == CNT_W'(1) && last_vld));
  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_pulse |=> (bl_vec == '0));
endmodule

bind mem_blacklist_sched mem_blacklist_sched_chk #(
  .NUM_APPS(NUM_APPS), .QDEPTH(QDEPTH), .APP_W(APP_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_app(req_app),
  .grant_valid(grant_valid), .grant_ready(grant_ready), .grant_idx(grant_idx),
  .bl_vec(bl_vec), .streak_cnt(streak_cnt), .last_app(last_app),
  .last_vld(last_vld), .clear_pulse(clear_pulse)
);

// File: tb/mem_blacklist_sched_bench.sv
`timescale 1ns/1ps
module mem_blacklist_sched_bench;
  localparam int NA = 4, QD = 8, AW = 2, GW = 8, IW = 3, THR = 4, CLR = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [QD-1:0]    req_valid = '0;
  logic [QD*AW-1:0] req_app = '0;
  logic [QD-1:0]    req_rowhit = '0;
  logic [QD*GW-1:0] req_age = '0;
  logic             grant_ready = 1'b0;
  logic             grant_valid;
  logic [IW-1:0]    grant_idx;

  always #2.5 clk = ~clk;

  mem_blacklist_sched u_mem_blacklist_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_app(req_app),
    .req_rowhit(req_rowhit), .req_age(req_age), .grant_ready(grant_ready),
    .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Staged queue contents and requirement-level model state.
  bit     s_v [QD];
  int     s_a [QD];
  bit     s_h [QD];
  int     s_g [QD];
  bit     m_bl [NA];
  int     m_cnt = 0, m_last = 0;
  bit     m_lv = 0;

  int     exp_q [$];
  string  tag_q [$];

  function automatic int model_pick();
    int best = -1;
    for (int i = 0; i < QD; i++) begin
      if (s_v[i]) begin
        if (best < 0) best = i;
        else if ({!m_bl[s_a[i]], s_h[i], s_g[i][7:0]} >
                 {!m_bl[s_a[best]], s_h[best], s_g[best][7:0]}) best = i;
      end
    end
    return best;
  endfunction

  task automatic clear_slots();
    for (int i = 0; i < QD; i++) begin
      s_v[i] = 0; s_a[i] = 0; s_h[i] = 0; s_g[i] = 0;
    end
  endtask

  task automatic put(input int i, input int app, input bit hit, input int age);
    s_v[i] = 1; s_a[i] = app; s_h[i] = hit; s_g[i] = age;
  endtask

  // Driver: applies staged slots for one cycle and pushes the expected grant.
  task automatic drive(input bit rdy, input string tag);
    int e;
    @(posedge clk); #1;
    for (int i = 0; i < QD; i++) begin
      req_valid[i] = s_v[i];
      req_app[i*AW +: AW] = AW'(s_a[i]);
      req_rowhit[i] = s_h[i];
      req_age[i*GW +: GW] = GW'(s_g[i]);
    end
    grant_ready = rdy;
    e = model_pick();
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (rdy && e >= 0) begin
      if (m_lv && m_last == s_a[e]) begin
        if (m_cnt < THR) m_cnt++;
      end else m_cnt = 1;
      m_last = s_a[e]; m_lv = 1;
      if (m_cnt >= THR) m_bl[s_a[e]] = 1;
    end
  endtask

  // Monitor: compares the grant against the scoreboard at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        int e; string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (e < 0) begin
          if (grant_valid !== 1'b0) begin
            failures++;
            $display("FAIL %s grant_valid=%0b expected 0", t, grant_valid);
          end
        end else if (grant_valid !== 1'b1 || int'(grant_idx) != e) begin
          failures++;
          $display("FAIL %s grant_valid=%0b grant_idx=%0d expected valid=1 idx=%0d",
                   t, grant_valid, grant_idx, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NA; a++) m_bl[a] = 0;
    clear_slots();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: empty queue offers nothing
    drive(1, "R1");
    // R9: nothing blacklisted after reset, so oldest wins across apps
    clear_slots();
    put(0, 0, 0, 3); put(1, 1, 0, 9); put(2, 2, 0, 20); put(3, 3, 0, 11);
    drive(0, "R9");
    // R4: oldest among row misses
    clear_slots();
    put(1, 1, 0, 30); put(4, 2, 0, 77); put(6, 3, 0, 12);
    drive(0, "R4");
    // R3: young row hit beats old miss
    clear_slots();
    put(0, 1, 0, 200); put(5, 2, 1, 4);
    drive(0, "R3");
    // R4: equal age and class, lowest index wins
    clear_slots();
    put(3, 1, 1, 40); put(6, 2, 1, 40); put(7, 3, 1, 40);
    drive(0, "R4");

    // R7: four back-to-back services of app 0 blacklist it
    clear_slots();
    put(0, 0, 1, 50); put(1, 1, 0, 10);
    for (int k = 0; k < THR; k++) drive(1, "R6");
    drive(0, "R7");
    drive(0, "R2");

    // R6: an interrupted streak does not blacklist
    clear_slots(); put(0, 2, 0, 40);
    for (int k = 0; k < 3; k++) drive(1, "R6");
    clear_slots(); put(0, 3, 0, 40);
    drive(1, "R6");
    clear_slots(); put(0, 2, 0, 40);
    for (int k = 0; k < 3; k++) drive(1, "R6");
    clear_slots(); put(0, 2, 0, 40); put(1, 1, 0, 5);
    drive(0, "R6");

    // R5: offers without ready never count as services
    clear_slots(); put(0, 3, 0, 60); put(1, 1, 0, 5);
    for (int k = 0; k < 6; k++) drive(0, "R5");

    // R2/R4: only blacklisted requests remain, ordering still applies
    clear_slots(); put(2, 0, 0, 7); put(5, 0, 0, 9);
    drive(0, "R2");
    clear_slots(); put(2, 0, 0, 9); put(5, 0, 0, 9);
    drive(0, "R4");

    // R8: after the clearing interval app 0 wins on age again
    clear_slots();
    drive(0, "R1");
    repeat (CLR + 10) @(posedge clk);
    for (int a = 0; a < NA; a++) m_bl[a] = 0;
    clear_slots(); put(0, 0, 0, 50); put(1, 1, 0, 10);
    drive(0, "R8");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule